// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block keeps a small set of recent virtual-to-physical page translations so that most address lookups avoid a page-table walk. A requester presents a virtual page number, a process identifier and a read/write flag. Every stored entry is compared against the request in parallel. On a hit, the physical page number and the entry's read and write permissions come back in the same cycle, together with a flag when a write meets a read-only page.

On a miss, the block holds off the requester and asks an external walker for the translation. The walker answers with a fill that carries the physical page number and permissions. The block writes the fill into a victim entry and then completes the held lookup. The victim is the lowest-numbered free entry if any entry is free, and otherwise an entry picked by a free-running pseudo-random sequence. Each entry is tagged with the process identifier, so processes can share the buffer. A flush input clears the whole buffer in one cycle when that is required.

Top module: `xlat_cache`

## Requirements
- R1: A lookup whose page number and process identifier both match a valid entry raises `lk_ready` in the same cycle, with that entry's physical page number on `lk_ppn` and its permissions on `lk_rd` and `lk_wr`. No walk is started. At most one entry matches at any time.
- R2: An entry matches only when its stored process identifier equals `lk_pid`. The same page number under another identifier is a miss.
- R3: A lookup that misses, with no flush in that cycle, keeps `lk_ready` low. From the next cycle, `walk_req` is high with the captured page number and identifier on `walk_vpn` and `walk_pid`, and it stays high until a fill arrives. `lk_ready` is low whenever `walk_req` is high.
- R4: The cycle after an accepted fill, `lk_ready` is high and the response carries the fill's page number and permissions. Later lookups of that page hit without a walk.
- R5: The fill goes into the lowest-numbered invalid entry when one exists, so installing up to the entry count of distinct pages after a flush evicts none of them. When every entry is valid, the victim index is taken from a 16-bit maximal-length LFSR that is never zero.
- R6: A high `flush` invalidates every entry by the next cycle. In a flush cycle `lk_ready` stays low and no walk is started.
- R7: An entry being rewritten is invalid in the cycle after the fill is captured. It turns valid, holding its new tags and permissions, only at the end of the completion cycle.
- R8: A fill that arrives after a flush during the same walk, or in the same cycle as a flush, is discarded. The block returns to idle, and a lookup that is still held misses again and starts a new walk.
- R9: A write lookup (`lk_write`=1) that completes on an entry whose write permission is 0 raises `lk_fault` together with `lk_ready`. The entry stays as it was.
- R10: After reset every entry is invalid, `walk_req` is low and `lk_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present; held until `lk_ready` |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_pid | input | PID_W | Lookup process identifier |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| lk_ready | output | 1 | Lookup completes this cycle |
| lk_ppn | output | PPN_W | Translated physical page number |
| lk_rd | output | 1 | Read permission of the translation |
| lk_wr | output | 1 | Write permission of the translation |
| lk_fault | output | 1 | Write access to a page without write permission |
| walk_req | output | 1 | Translation walk requested |
| walk_vpn | output | VPN_W | Page number to walk |
| walk_pid | output | PID_W | Process identifier to walk |
| fill_valid | input | 1 | Walk result present for one cycle |
| fill_ppn | input | PPN_W | Walked physical page number |
| fill_rd | input | 1 | Walked read permission |
| fill_wr | input | 1 | Walked write permission |
| flush | input | 1 | Invalidate all entries |

## Verification
Flush and fill are the two functions that can land in the same cycle. The bench provokes this in two ways. In one case it pulses flush while a walk is pending and returns a wrong fill afterwards. In the other it drives a wrong fill and flush together in a single cycle. The bench judges both cases at the ports. The wrong page number must never show up in a response. The walk counter must rise by two, because the held lookup misses again and is served by a second, correct walk.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_FINISH
  } walk_state_e;

  localparam int RAND_W = 16;
  localparam logic [RAND_W-1:0] RAND_TAPS = 16'hB400;
  localparam logic [RAND_W-1:0] RAND_SEED = 16'hACE1;

  // One Galois step of the victim sequence
  function automatic logic [RAND_W-1:0] rand_step(input logic [RAND_W-1:0] s);
    rand_step = s[0] ? ((s >> 1) ^ RAND_TAPS) : (s >> 1);
  endfunction

endpackage

// File: rtl/xlat_rand.sv
module xlat_rand
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] rand_idx
);

  logic [RAND_W-1:0] seq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seq_q <= RAND_SEED;
    else        seq_q <= rand_step(seq_q);
  end

  assign rand_idx = IDX_W'(seq_q % RAND_W'(ENTRIES));

  // R5: sequence never collapses to the all-zero lock-up state
  p_rand_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q != '0);

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld_vec,
  input  logic [IDX_W-1:0]   rand_idx,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               free_hit
);

  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_vec[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim_idx = free_hit ? free_idx : rand_idx;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int PID_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_write,
  output logic             lk_ready,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_rd,
  output logic             lk_wr,
  output logic             lk_fault,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  output logic [PID_W-1:0] walk_pid,
  input  logic             fill_valid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             flush
);

  function automatic logic tag_eq(input logic [VPN_W-1:0] ev, input logic [PID_W-1:0] ep,
                                  input logic [VPN_W-1:0] qv, input logic [PID_W-1:0] qp);
    tag_eq = (ev == qv) && (ep == qp);
  endfunction

  // Entry storage
  logic [ENTRIES-1:0] vld_vec;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PID_W-1:0]   ent_pid [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];
  logic [ENTRIES-1:0] ent_rd;
  logic [ENTRIES-1:0] ent_wr;

  // Pending walk
  walk_state_e      state_q;
  logic             abort_q;
  logic [VPN_W-1:0] pend_vpn;
  logic [PID_W-1:0] pend_pid;
  logic             pend_write;
  logic [PPN_W-1:0] pend_ppn;
  logic             pend_rd;
  logic             pend_wr;
  logic [IDX_W-1:0] fill_idx;

  // Parallel compare
  logic [ENTRIES-1:0] match_vec;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = vld_vec[g] && tag_eq(ent_vpn[g], ent_pid[g], lk_vpn, lk_pid);
  end

  logic             hit;
  logic [PPN_W-1:0] hit_ppn;
  logic             hit_rd;
  logic             hit_wr;

  assign hit = |match_vec;

  always_comb begin
    hit_ppn = '0;
    hit_rd  = 1'b0;
    hit_wr  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_ppn = hit_ppn | ent_ppn[i];
        hit_rd  = hit_rd | ent_rd[i];
        hit_wr  = hit_wr | ent_wr[i];
      end
    end
  end

  // Victim selection
  logic [IDX_W-1:0] rand_idx;
  logic [IDX_W-1:0] victim_idx;
  logic             free_hit;

  xlat_rand #(.ENTRIES(ENTRIES)) u_rand (
    .clk      (clk),
    .rst_n    (rst_n),
    .rand_idx (rand_idx)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .vld_vec    (vld_vec),
    .rand_idx   (rand_idx),
    .victim_idx (victim_idx),
    .free_hit   (free_hit)
  );

  // Named internal events
  logic ev_miss_start;
  logic ev_fill_write;
  logic ev_fill_drop;
  logic ev_finish;

  assign ev_miss_start = (state_q == ST_IDLE) && lk_valid && !hit && !flush;
  assign ev_fill_write = (state_q == ST_WALK) && fill_valid && !flush && !abort_q;
  assign ev_fill_drop  = (state_q == ST_WALK) && fill_valid && (flush || abort_q);
  assign ev_finish     = (state_q == ST_FINISH) && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      abort_q    <= 1'b0;
      vld_vec    <= '0;
      pend_vpn   <= '0;
      pend_pid   <= '0;
      pend_write <= 1'b0;
      pend_ppn   <= '0;
      pend_rd    <= 1'b0;
      pend_wr    <= 1'b0;
      fill_idx   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ev_miss_start) begin
            pend_vpn   <= lk_vpn;
            pend_pid   <= lk_pid;
            pend_write <= lk_write;
            abort_q    <= 1'b0;
            state_q    <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (flush) abort_q <= 1'b1;
          if (ev_fill_drop) begin
            state_q <= ST_IDLE;
          end else if (ev_fill_write) begin
            vld_vec[victim_idx] <= 1'b0;
            ent_vpn[victim_idx] <= pend_vpn;
            ent_pid[victim_idx] <= pend_pid;
            ent_ppn[victim_idx] <= fill_ppn;
            ent_rd[victim_idx]  <= fill_rd;
            ent_wr[victim_idx]  <= fill_wr;
            pend_ppn <= fill_ppn;
            pend_rd  <= fill_rd;
            pend_wr  <= fill_wr;
            fill_idx <= victim_idx;
            state_q  <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          if (ev_finish) vld_vec[fill_idx] <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (flush) vld_vec <= '0;
    end
  end

  // Outputs
  logic finishing;
  logic cur_write;
  logic cur_wperm;

  assign finishing = (state_q == ST_FINISH);
  assign lk_ready  = !flush && (finishing || ((state_q == ST_IDLE) && lk_valid && hit));
  assign lk_ppn    = finishing ? pend_ppn : hit_ppn;
  assign lk_rd     = finishing ? pend_rd  : hit_rd;
  assign lk_wr     = finishing ? pend_wr  : hit_wr;
  assign cur_write = finishing ? pend_write : lk_write;
  assign cur_wperm = finishing ? pend_wr : hit_wr;
  assign lk_fault  = lk_ready && cur_write && !cur_wperm;
  assign walk_req  = (state_q == ST_WALK);
  assign walk_vpn  = pend_vpn;
  assign walk_pid  = pend_pid;

  // R1: no two entries ever claim the same tag
  p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R3: a miss launches a walk for the captured tag
  p_walk_after_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss_start |=> (walk_req && walk_vpn == $past(lk_vpn) && walk_pid == $past(lk_pid)));

  // R3: requester is stalled while a walk is pending
  p_stall_in_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !lk_ready);

  // R5: a free entry is always preferred over the random pick
  p_free_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill_write && !(&vld_vec)) |-> !vld_vec[victim_idx]);

  // R6: flush empties the buffer by the next cycle
  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_vec == '0));

  // R7: rewritten entry is invalid before it is revalidated
  p_invalid_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_write |=> !vld_vec[fill_idx]);

  p_valid_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> vld_vec[$past(fill_idx)]);

  // R8: a dropped fill installs nothing
  p_drop_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_drop |=> ((vld_vec == '0) && !walk_req));

  // R9: a faulting hit leaves the entries untouched
  p_fault_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && lk_fault) |=> $stable(vld_vec));

endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;

  localparam int ENTRIES = 8;
  localparam int VPN_W   = 20;
  localparam int PPN_W   = 16;
  localparam int PID_W   = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lk_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [PID_W-1:0] lk_pid = '0;
  logic             lk_write = 1'b0;
  logic             lk_ready;
  logic [PPN_W-1:0] lk_ppn;
  logic             lk_rd;
  logic             lk_wr;
  logic             lk_fault;
  logic             walk_req;
  logic [VPN_W-1:0] walk_vpn;
  logic [PID_W-1:0] walk_pid;
  logic             fill_valid = 1'b0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic             fill_rd = 1'b0;
  logic             fill_wr = 1'b0;
  logic             flush = 1'b0;

  always #10 clk = ~clk;

  xlat_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_write(lk_write),
    .lk_ready(lk_ready), .lk_ppn(lk_ppn), .lk_rd(lk_rd), .lk_wr(lk_wr), .lk_fault(lk_fault),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_pid(walk_pid),
    .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .flush(flush)
  );

  int checks = 0;
  int fails  = 0;
  int walks  = 0;
  logic auto_walk = 1'b1;
  logic [VPN_W-1:0] cur_vpn = '0;
  logic [PID_W-1:0] cur_pid = '0;

  // Page-table model
  function automatic logic [PPN_W-1:0] pt_ppn(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p);
    pt_ppn = (v[PPN_W-1:0] ^ 16'h5A00) + 16'(p) * 16'd77;
  endfunction
  function automatic logic pt_wr(input logic [VPN_W-1:0] v);
    pt_wr = ~v[1];
  endfunction

  typedef struct {
    logic [PPN_W-1:0] ppn;
    logic             rd;
    logic             wr;
    logic             fault;
    string            req;
  } exp_t;
  exp_t sb[$];

  task automatic check(input logic ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Monitor: compares every completed lookup with the scoreboard
  always @(negedge clk) begin
    if (rst_n && lk_valid && lk_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected response", longint'(lk_ppn), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(lk_ppn == e.ppn, {e.req, " ppn"}, longint'(lk_ppn), longint'(e.ppn));
        check({lk_rd, lk_wr, lk_fault} == {e.rd, e.wr, e.fault}, {e.req, " perms/fault"},
              longint'({lk_rd, lk_wr, lk_fault}), longint'({e.rd, e.wr, e.fault}));
      end
    end
  end

  // Walk counter
  logic walk_prev = 1'b0;
  always @(negedge clk) begin
    if (walk_req && !walk_prev) walks++;
    walk_prev = walk_req;
  end

  // Automatic walker
  initial begin
    forever begin
      @(negedge clk);
      if (auto_walk && walk_req) begin
        check(walk_vpn == cur_vpn && walk_pid == cur_pid, "R3 walk tag",
              longint'({walk_vpn, walk_pid}), longint'({cur_vpn, cur_pid}));
        @(posedge clk); #2;
        fill_valid = 1'b1;
        fill_ppn   = pt_ppn(walk_vpn, walk_pid);
        fill_rd    = 1'b1;
        fill_wr    = pt_wr(walk_vpn);
        @(posedge clk); #2;
        fill_valid = 1'b0;
        @(negedge clk);
        check(lk_ready == 1'b1, "R4 R7 completion cycle after fill", longint'(lk_ready), 1);
      end
    end
  end

  task automatic start_req(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                           input logic w, input string req);
    exp_t e;
    e.ppn = pt_ppn(v, p); e.rd = 1'b1; e.wr = pt_wr(v);
    e.fault = w && !pt_wr(v); e.req = req;
    sb.push_back(e);
    cur_vpn  = v;
    cur_pid  = p;
    lk_valid = 1'b1;
    lk_vpn   = v;
    lk_pid   = p;
    lk_write = w;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!lk_ready);
    @(posedge clk); #2;
    lk_valid = 1'b0;
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                        input logic w, input string req);
    @(posedge clk); #2;
    start_req(v, p, w, req);
    wait_done();
  endtask

  task automatic pulse_flush();
    @(posedge clk); #2;
    flush = 1'b1;
    @(posedge clk); #2;
    flush = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(walk_req == 1'b0, "R10 walk_req after reset", longint'(walk_req), 0);
    check(lk_ready == 1'b0, "R10 ready after reset", longint'(lk_ready), 0);

    // R3 R4: first lookup misses and is filled
    w0 = walks;
    lookup(20'h00100, 6'd1, 1'b0, "R4 first fill");
    check(walks == w0 + 1, "R3 miss walks", walks, w0 + 1);

    // R1: repeat hits without a walk
    w0 = walks;
    lookup(20'h00100, 6'd1, 1'b0, "R1 hit");
    check(walks == w0, "R1 hit no walk", walks, w0);

    // R2: other process identifier misses
    w0 = walks;
    lookup(20'h00100, 6'd2, 1'b0, "R2 other pid");
    check(walks == w0 + 1, "R2 pid miss walks", walks, w0 + 1);

    // R9: write to read-only page
    w0 = walks;
    lookup(20'h00102, 6'd1, 1'b1, "R9 fault on fill");
    lookup(20'h00102, 6'd1, 1'b1, "R9 fault on hit");
    lookup(20'h00102, 6'd1, 1'b0, "R9 read after fault");
    check(walks == w0 + 1, "R9 entry kept", walks, w0 + 1);

    // R6: flush together with a lookup of an installed page
    w0 = walks;
    @(posedge clk); #2;
    start_req(20'h00100, 6'd1, 1'b0, "R6 after flush");
    flush = 1'b1;
    @(negedge clk);
    check(lk_ready == 1'b0, "R6 no ready in flush cycle", longint'(lk_ready), 0);
    @(posedge clk); #2;
    flush = 1'b0;
    wait_done();
    check(walks == w0 + 1, "R6 flushed page walks", walks, w0 + 1);

    // R5: free entries are used first
    pulse_flush();
    w0 = walks;
    for (int i = 0; i < ENTRIES; i++) lookup(20'h00200 + 20'(i), 6'd3, 1'b0, "R5 install");
    check(walks == w0 + ENTRIES, "R5 install walks", walks, w0 + ENTRIES);
    w0 = walks;
    for (int i = 0; i < ENTRIES; i++) lookup(20'h00200 + 20'(i), 6'd3, 1'b0, "R5 rehit");
    check(walks == w0, "R5 no eviction while free", walks, w0);

    // R5: full buffer evicts a random entry
    w0 = walks;
    lookup(20'h00300, 6'd3, 1'b0, "R5 ninth");
    lookup(20'h00300, 6'd3, 1'b0, "R5 ninth rehit");
    check(walks == w0 + 1, "R5 ninth installed", walks, w0 + 1);
    w0 = walks;
    for (int i = 0; i < ENTRIES; i++) lookup(20'h00200 + 20'(i), 6'd3, 1'b0, "R5 probe");
    check(walks > w0 && walks <= w0 + ENTRIES, "R5 one eviction seen", walks - w0, 1);

    // R8: flush during a pending walk, wrong fill later
    w0 = walks;
    auto_walk = 1'b0;
    @(posedge clk); #2;
    start_req(20'h00400, 6'd5, 1'b0, "R8 flush then fill");
    do @(negedge clk); while (!walk_req);
    pulse_flush();
    fill_valid = 1'b1; fill_ppn = 16'hDEAD; fill_rd = 1'b1; fill_wr = 1'b1;
    @(posedge clk); #2;
    fill_valid = 1'b0;
    auto_walk  = 1'b1;
    wait_done();
    check(walks == w0 + 2, "R8 rewalk after flush", walks, w0 + 2);

    // R8: flush and wrong fill in the same cycle
    w0 = walks;
    auto_walk = 1'b0;
    @(posedge clk); #2;
    start_req(20'h00500, 6'd6, 1'b0, "R8 same-cycle");
    do @(negedge clk); while (!walk_req);
    @(posedge clk); #2;
    fill_valid = 1'b1; fill_ppn = 16'hBEEF; fill_rd = 1'b1; fill_wr = 1'b1;
    flush = 1'b1;
    @(posedge clk); #2;
    fill_valid = 1'b0;
    flush = 1'b0;
    auto_walk = 1'b1;
    wait_done();
    check(walks == w0 + 2, "R8 same-cycle rewalk", walks, w0 + 2);

    repeat (4) @(posedge clk);
    check(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);
    finish_run();
  end

endmodule